// File: doc/BRIEF.md
# Keyed Low-Speed Clock Selector

This block produces the low-speed clock of a chip from one of two sources: a fast internal RC oscillator, brought down to low speed by a divider chain, or an external 32 kHz crystal. On the internal path a fixed prescaler, chosen at synthesis time, runs first. A 5-bit programmable prescaler follows it. A small register port on the bus clock holds the source select, the programmable divide value and an enable for a buffered copy of the selected clock on an output pin.

A stray write must not be able to change the clock source. For that reason the control register only takes a write whose upper half carries a fixed 16-bit key. Any other write to it is dropped. The divider reloads a new divide value only at the end of its current period, so the divided clock never shows a shortened high or low phase. The source select is a plain registered mux. Glitch-free switching between the two unrelated clocks is not attempted.

Top module: `lsc_clk_select`

## Requirements
- R1: A write to the control register (offset 0x00) changes it only when write data bits 31:16 equal 16'h16AA; any other write to that offset leaves the register and the output clock unchanged.
- R2: Control bit 0 picks the source: 1 routes the external crystal to `lsc_clk`, 0 routes the divided internal clock; after reset it is 0.
- R3: A read of the control register returns the select in bit 0 and zero in bits 31:1, including the key field.
- R4: The prescaler register (offset 0x08) holds N in bits 4:0, needs no key, reads back N with bits 31:5 zero, and is 0 after reset.
- R5: When the internal source is selected, `lsc_clk` has a period of FIX_DIV*(N+1) `rc_clk` cycles and is high for the first floor(period/2) of them (FIX_DIV defaults to 32; FIX_DIV=1 bypasses the fixed stage, and then N=0 passes `rc_clk` straight through).
- R6: A new N takes effect only at the divider's terminal count, so every period of the divided clock is a complete period of either the old or the new divide value.
- R7: Gate register (offset 0x60) bit 0 enables the pin output: when 1, `lsc_pin` follows `lsc_clk`; when 0, `lsc_pin` is held low; after reset it is 0.
- R8: Offsets other than 0x00, 0x08 and 0x60 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register port clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| reg_wr | input | 1 | Write strobe, sampled on `bus_clk` |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| rc_clk | input | 1 | Internal RC oscillator clock |
| xtal_clk | input | 1 | External 32 kHz crystal clock |
| lsc_clk | output | 1 | Selected low-speed clock |
| lsc_pin | output | 1 | Gated copy of `lsc_clk` for the output pin |

## Verification
The hardest case to reach is a divide-value change that lands inside a running period. A loaded value that takes effect at once would cut that period short. The bench queues its expected periods first, waits until the period monitor has locked onto a rising edge, and only then writes the new N part way into the measured period. Every period it records across the change must then equal one of the two legal lengths, with a half-length high phase. Writes with a near-miss key, and writes with no key at all, are followed by reading the select back and measuring the output period.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    localparam int          DATA_W   = 32;
    localparam int          ADDR_W   = 8;
    localparam int          NDIV_W   = 5;
    localparam logic [15:0] CTRL_KEY = 16'h16AA;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PRESC = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_GATE  = 8'h60;

    typedef struct packed {
        logic              ext_sel;
        logic [NDIV_W-1:0] div_n;
        logic              pin_en;
    } lsc_cfg_t;

    function automatic logic key_ok(input logic [DATA_W-1:0] wdata);
        return wdata[DATA_W-1:DATA_W-16] == CTRL_KEY;
    endfunction

endpackage

// File: rtl/lsc_regs.sv
module lsc_regs
    import lsc_pkg::*;
(
    input  logic              bus_clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output lsc_cfg_t          cfg
);

    always_ff @(posedge bus_clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_CTRL:  if (key_ok(reg_wdata)) cfg.ext_sel <= reg_wdata[0];
                OFS_PRESC: cfg.div_n  <= reg_wdata[NDIV_W-1:0];
                OFS_GATE:  cfg.pin_en <= reg_wdata[0];
                default:   ;
            endcase
        end
    end

    // Key field always reads back as zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL:  reg_rdata[0]          = cfg.ext_sel;
            OFS_PRESC: reg_rdata[NDIV_W-1:0] = cfg.div_n;
            OFS_GATE:  reg_rdata[0]          = cfg.pin_en;
            default:   reg_rdata             = '0;
        endcase
    end

endmodule

// File: rtl/lsc_fixed_stage.sv
module lsc_fixed_stage #(
    parameter int FIX_DIV = 32,
    localparam int FW = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1
) (
    input  logic          rc_clk,
    input  logic          rst,
    output logic [FW-1:0] f_cnt,
    output logic          f_wrap
);

    generate
        if (FIX_DIV == 1) begin : g_bypass
            assign f_cnt  = '0;
            assign f_wrap = 1'b1;
        end else begin : g_count
            localparam logic [FW-1:0] F_LAST = FW'(FIX_DIV - 1);
            logic [FW-1:0] cnt_q;
            always_ff @(posedge rc_clk) begin
                if (rst || cnt_q == F_LAST) cnt_q <= '0;
                else                        cnt_q <= cnt_q + FW'(1);
            end
            assign f_cnt  = cnt_q;
            assign f_wrap = (cnt_q == F_LAST);
        end
    endgenerate

endmodule

// File: rtl/lsc_prog_stage.sv
module lsc_prog_stage
    import lsc_pkg::*;
#(
    parameter int FIX_DIV = 32,
    localparam int FW = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1,
    localparam int LW = $clog2((1 << NDIV_W) * FIX_DIV + 1)
) (
    input  logic              rc_clk,
    input  logic              rst,
    input  logic [FW-1:0]     f_cnt,
    input  logic              f_wrap,
    input  logic [NDIV_W-1:0] n_req,
    output logic [NDIV_W-1:0] n_active,
    output logic              at_term,
    output logic [LW-1:0]     phase,
    output logic [LW-1:0]     div_len,
    output logic              div_q
);

    logic [NDIV_W-1:0] p_cnt;

    assign at_term = f_wrap && (p_cnt == n_active);
    assign phase   = LW'(p_cnt) * LW'(FIX_DIV) + LW'(f_cnt);
    assign div_len = (LW'(n_active) + LW'(1)) * LW'(FIX_DIV);

    // New divide value is loaded only at terminal count.
    always_ff @(posedge rc_clk) begin
        if (rst) begin
            p_cnt    <= '0;
            n_active <= '0;
            div_q    <= 1'b0;
        end else begin
            div_q <= phase < (div_len >> 1);
            if (at_term) begin
                p_cnt    <= '0;
                n_active <= n_req;
            end else if (f_wrap) begin
                p_cnt <= p_cnt + NDIV_W'(1);
            end
        end
    end

endmodule

// File: rtl/lsc_clk_select.sv
module lsc_clk_select
    import lsc_pkg::*;
#(
    parameter int FIX_DIV = 32
) (
    input  logic              bus_clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rc_clk,
    input  logic              xtal_clk,
    output logic              lsc_clk,
    output logic              lsc_pin
);

    localparam int FW = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;
    localparam int LW = $clog2((1 << NDIV_W) * FIX_DIV + 1);

    lsc_cfg_t          cfg;
    logic [FW-1:0]     f_cnt;
    logic              f_wrap;
    logic [NDIV_W-1:0] n_active;
    logic              at_term;
    logic [LW-1:0]     phase;
    logic [LW-1:0]     div_len;
    logic              div_q;
    logic              int_clk;

    lsc_regs u_regs (
        .bus_clk   (bus_clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg       (cfg)
    );

    lsc_fixed_stage #(.FIX_DIV(FIX_DIV)) u_fixed (
        .rc_clk (rc_clk),
        .rst    (rst),
        .f_cnt  (f_cnt),
        .f_wrap (f_wrap)
    );

    lsc_prog_stage #(.FIX_DIV(FIX_DIV)) u_prog (
        .rc_clk   (rc_clk),
        .rst      (rst),
        .f_cnt    (f_cnt),
        .f_wrap   (f_wrap),
        .n_req    (cfg.div_n),
        .n_active (n_active),
        .at_term  (at_term),
        .phase    (phase),
        .div_len  (div_len),
        .div_q    (div_q)
    );

    generate
        if (FIX_DIV == 1) begin : g_pass
            assign int_clk = (n_active == '0) ? rc_clk : div_q;
        end else begin : g_div
            assign int_clk = div_q;
        end
    endgenerate

    assign lsc_clk = cfg.ext_sel ? xtal_clk : int_clk;
    assign lsc_pin = cfg.pin_en & lsc_clk;

endmodule

// File: rtl/lsc_clk_select_chk.sv
module lsc_clk_select_chk
    import lsc_pkg::*;
#(
    parameter int FIX_DIV = 32,
    localparam int LW = $clog2((1 << NDIV_W) * FIX_DIV + 1)
) (
    input logic              bus_clk,
    input logic              rc_clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              ext_sel,
    input logic              pin_en,
    input logic              lsc_pin,
    input logic [NDIV_W-1:0] n_active,
    input logic              at_term,
    input logic [LW-1:0]     phase,
    input logic [LW-1:0]     div_len
);

    assert_unkeyed_ignored_R1: assert property (@(posedge bus_clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_CTRL && reg_wdata[31:16] != CTRL_KEY) |=> $stable(ext_sel));

    assert_keyed_select_R2: assert property (@(posedge bus_clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_CTRL && reg_wdata[31:16] == CTRL_KEY) |=> (ext_sel == $past(reg_wdata[0])));

    assert_ctrl_read_R3: assert property (@(posedge bus_clk) disable iff (rst)
        (reg_addr == OFS_CTRL) |-> (reg_rdata[31:1] == '0));

    assert_phase_range_R5: assert property (@(posedge rc_clk) disable iff (rst)
        phase < div_len);

    assert_load_at_term_R6: assert property (@(posedge rc_clk) disable iff (rst)
        !$stable(n_active) |-> $past(at_term));

    assert_pin_gated_R7: assert property (@(posedge bus_clk) disable iff (rst)
        !pin_en |-> !lsc_pin);

endmodule

bind lsc_clk_select lsc_clk_select_chk #(.FIX_DIV(FIX_DIV)) u_chk (
    .bus_clk   (bus_clk),
    .rc_clk    (rc_clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ext_sel   (cfg.ext_sel),
    .pin_en    (cfg.pin_en),
    .lsc_pin   (lsc_pin),
    .n_active  (n_active),
    .at_term   (at_term),
    .phase     (phase),
    .div_len   (div_len)
);

// File: tb/test_lsc_clk_select.sv
module test_lsc_clk_select;
    import lsc_pkg::*;

    logic        bus_clk = 0, rc_clk = 0, xtal_clk = 0, rst = 1, reg_wr = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata, rd_val;
    logic        lsc_clk, lsc_pin;

    int n_checks = 0, n_err = 0;
    bit done = 0;

    always #4 bus_clk = ~bus_clk;      // 125 MHz
    always #2 rc_clk = ~rc_clk;        // internal source, 4 ns
    initial begin #1; forever #20 xtal_clk = ~xtal_clk; end  // 10 rc periods

    lsc_clk_select i_lsc_clk_select (
        .bus_clk(bus_clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rc_clk(rc_clk),
        .xtal_clk(xtal_clk), .lsc_clk(lsc_clk), .lsc_pin(lsc_pin)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge bus_clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge bus_clk); reg_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge bus_clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    // Scoreboard of expected periods, in rc_clk cycles.
    typedef struct { int a; int b; string req; } exp_t;
    exp_t exp_q[$];
    bit   armed = 0;
    int   hi_c = 0, lo_c = 0;
    logic prev = 0;

    task automatic push(string req, int a, int b);
        exp_q.push_back('{a, b, req});
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
    endtask

    always @(negedge rc_clk) begin : monitor
        exp_t e;
        int   per, pick;
        if (!rst) begin
            if (lsc_clk && !prev) begin
                if (armed && exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    per = hi_c + lo_c;
                    pick = (per == e.a) ? e.a : e.b;
                    n_checks++;
                    if (!((per == e.a || per == e.b) && hi_c == pick / 2)) begin
                        n_err++;
                        $display("FAIL %s: actual period %0d high %0d expected period %0d or %0d high half",
                                 e.req, per, hi_c, e.a, e.b);
                    end
                    if (exp_q.size() == 0) armed = 0;
                end else if (exp_q.size() > 0) begin
                    armed = 1;
                end
                hi_c = 1; lo_c = 0;
            end else if (lsc_clk) hi_c++;
            else lo_c++;
            prev = lsc_clk;
        end
    end

    task automatic pin_check(string req, bit en);
        int mism = 0, highs = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge rc_clk);
            if (lsc_pin !== (en ? lsc_clk : 1'b0)) mism++;
            if (lsc_pin) highs++;
        end
        check(req, mism, 0);
        if (en) check(req, (highs > 0) ? 1 : 0, 1);
    endtask

    initial begin
        repeat (20) @(posedge bus_clk);
        @(negedge bus_clk) rst = 0;

        rd(OFS_CTRL, rd_val);  check("R2 reset select", rd_val, 0);
        rd(OFS_PRESC, rd_val); check("R4 reset N", rd_val, 0);
        rd(OFS_GATE, rd_val);  check("R7 reset gate", rd_val, 0);
        push("R5 N=0", 32, 32); drain();

        wr(OFS_PRESC, 3); #5000; push("R5 N=3", 128, 128); drain();
        wr(OFS_PRESC, 6); #5000; push("R5 N=6", 224, 224); drain();
        wr(OFS_PRESC, 32'hFFFF_FFFF);
        rd(OFS_PRESC, rd_val); check("R4 upper bits dropped", rd_val, 31);
        #5000; push("R5 N=31", 1024, 1024); drain();
        wr(OFS_PRESC, 1); #5000; push("R5 N=1", 64, 64); drain();

        // R6: change N in the middle of a measured period
        for (int i = 0; i < 4; i++) push("R6 no truncated period", 64, 96);
        wait (armed); #30;
        wr(OFS_PRESC, 2);
        drain();
        push("R6 new N=2", 96, 96); drain();

        wr(OFS_CTRL, 32'h16AB_0001);
        rd(OFS_CTRL, rd_val); check("R1 wrong key", rd_val, 0);
        wr(OFS_CTRL, 32'h0000_0001);
        rd(OFS_CTRL, rd_val); check("R1 no key", rd_val, 0);
        #1000; push("R1 still internal", 96, 96); drain();

        wr(OFS_CTRL, 32'h16AA_0001);
        rd(OFS_CTRL, rd_val); check("R3 key field reads zero", rd_val, 1);
        #1000; push("R2 crystal selected", 10, 10); drain();

        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, rd_val);     check("R8 unused offset", rd_val, 0);
        rd(OFS_CTRL, rd_val);  check("R8 ctrl untouched", rd_val, 1);
        rd(OFS_PRESC, rd_val); check("R8 presc untouched", rd_val, 2);

        pin_check("R7 gate off", 0);
        wr(OFS_GATE, 1);
        rd(OFS_GATE, rd_val); check("R7 gate readback", rd_val, 1);
        pin_check("R7 gate on crystal", 1);

        wr(OFS_CTRL, 32'h16AA_0000);
        #1000; push("R2 back to internal", 96, 96); drain();
        pin_check("R7 gate on internal", 1);
        wr(OFS_GATE, 0);
        pin_check("R7 gate off again", 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge bus_clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule